// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block produces the 16x sampling enables that a serial receiver and transmitter need. It has two sources. The first is a 16-bit programmable timer: its preset is loaded one byte at a time, and the timer starts only when the host reads a particular address. The second is a small set of fixed rates derived from the input clock by a prescaler followed by binary division. A clock-select byte picks the source for each direction on its own. Its upper nibble serves the receiver and its lower nibble serves the transmitter.

The host side is a simple byte bus. Each access lasts one cycle, with a strobe and a write flag, and there is no read data path. Reads matter only for their side effect on the start address. Both outputs are single-cycle enable pulses in the input clock domain, so a serial engine can use them directly as clock enables.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the timer is stopped, both direction selects hold the silent code 0xF, and neither rx_tick nor tx_tick pulses.
- R2: A bus write to address 6 sets the upper preset byte and a write to address 7 sets the lower byte. A running timer with preset P gives one enable every 2*P clocks, so the 16x rate is clk/(2*P) and the baud rate is clk/(32*P).
- R3: Only a bus read of address 0xE (bus_en=1, bus_we=0) starts the timer. A write to 0xE and reads of other addresses do not start it. After a start captured at edge E0, the first enable is visible in the cycle after edge E0+2*P.
- R4: On reaching terminal count the timer reloads the preset by itself, and enables then repeat every 2*P clocks.
- R5: A preset write does not change the running count. It is taken up at the next reload or start. A preset write captured on the same edge as a reload is not seen by that reload; the period that follows still uses the old preset.
- R6: Preset values 0 and 1 act as 2, which gives one enable every 4 clocks.
- R7: The timer counts only while bits [6:4] of the auxiliary register (address 4) equal 6. With any other value it holds its count and emits no enables. It resumes counting when the mode is restored.
- R8: The clock-select register is write-only at address 1. Bits [7:4] pick the receive source and bits [3:0] pick the transmit source. Code 0xD routes the timer to that direction, and the two directions select independently.
- R9: Codes 0 to 3 pick fixed rates with a period of B*2^code clocks. B is 6 when auxiliary bit 7 is 0 and 10 when it is 1.
- R10: Codes other than 0x0 to 0x3 and 0xD produce no enables on that direction.
- R11: A start read captured on the same edge as a terminal count wins. The count restarts from the preset, no enable is produced for that edge, and the next enable comes 2*P clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the timer and prescaler time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| rx_tick | output | 1 | 16x enable for the receiver |
| tx_tick | output | 1 | 16x enable for the transmitter |

## Verification
Two of the timer's functions can land on the same clock edge: the automatic reload at terminal count, and a host action that wants the count. The bench provokes both collisions. It times a lower-preset write, and separately a start read, so that each is captured exactly on the edge where the count expires. For the write, it judges by the reload still using the old preset for one more period before the new one appears. For the read, the restart must suppress that edge's enable and push the next one a full 2*P clocks out.

// File: rtl/btg_pkg.sv
package btg_pkg;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] ADR_CLKSEL = 4'h1;
   localparam logic [ADDR_W-1:0] ADR_AUX    = 4'h4;
   localparam logic [ADDR_W-1:0] ADR_PRE_HI = 4'h6;
   localparam logic [ADDR_W-1:0] ADR_PRE_LO = 4'h7;
   localparam logic [ADDR_W-1:0] ADR_GO     = 4'hE;

   localparam logic [3:0] SRC_TIMER  = 4'hD;
   localparam logic [3:0] SRC_SILENT = 4'hF;
   localparam logic [2:0] MODE_TIMER = 3'd6;

   typedef struct packed {
      logic [3:0] rx;
      logic [3:0] tx;
   } clk_sel_t;

endpackage

// File: rtl/btg_regs.sv
module btg_regs
   import btg_pkg::*;
#(
   parameter int PRESET_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output clk_sel_t             clk_sel,
   output logic                 mode_on,
   output logic                 set_b,
   output logic [PRESET_W-1:0]  preset,
   output logic                 go
);

   localparam int HI_W = PRESET_W - DATA_W;

   logic [HI_W-1:0]   pre_hi_q;
   logic [DATA_W-1:0] pre_lo_q;
   logic [2:0]        mode_q;
   logic              setb_q;
   clk_sel_t          sel_q;

   logic wr_any;
   assign wr_any = bus_en && bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_hi_q <= '0;
         pre_lo_q <= '0;
         mode_q   <= '0;
         setb_q   <= 1'b0;
         sel_q    <= '{rx: SRC_SILENT, tx: SRC_SILENT};
      end else if (wr_any) begin
         case (bus_addr)
            ADR_CLKSEL: sel_q    <= clk_sel_t'(bus_wdata);
            ADR_AUX: begin
               mode_q <= bus_wdata[6:4];
               setb_q <= bus_wdata[7];
            end
            ADR_PRE_HI: pre_hi_q <= bus_wdata[HI_W-1:0];
            ADR_PRE_LO: pre_lo_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign preset  = {pre_hi_q, pre_lo_q};
   assign clk_sel = sel_q;
   assign mode_on = (mode_q == MODE_TIMER);
   assign set_b   = setb_q;
   assign go      = bus_en && !bus_we && (bus_addr == ADR_GO);

   // a start is never a write
   AST_GO_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !bus_we) else $error("start decoded on a write"); // R3

endmodule

// File: rtl/btg_timer.sv
module btg_timer #(
   parameter int PRESET_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                mode_on,
   input  logic [PRESET_W-1:0] preset,
   output logic                tick
);

   localparam logic [PRESET_W-1:0] MIN_LOAD = PRESET_W'(2);
   localparam logic [PRESET_W-1:0] ONE      = PRESET_W'(1);

   logic [PRESET_W-1:0] cnt_q;
   logic                run_q;
   logic                half_q;
   logic                tick_q;
   logic [PRESET_W-1:0] load_val;

   assign load_val = (preset < MIN_LOAD) ? MIN_LOAD : preset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         half_q <= 1'b0;
         tick_q <= 1'b0;
      end else if (go) begin
         cnt_q  <= load_val;
         run_q  <= 1'b1;
         half_q <= 1'b0;
         tick_q <= 1'b0;
      end else if (run_q && mode_on) begin
         half_q <= !half_q;
         tick_q <= 1'b0;
         if (half_q) begin
            if (cnt_q == ONE) begin
               cnt_q  <= load_val;
               tick_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;

   AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !tick_q) else $error("enable while stopped"); // R1
   AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0)) else $error("count reached zero"); // R6
   AST_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (run_q && !tick_q)) else $error("start did not restart"); // R11
   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q) else $error("back to back enables"); // R4
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_on && !go) |=> $stable(cnt_q)) else $error("count moved out of timer mode"); // R7

endmodule

// File: rtl/btg_fixed.sv
module btg_fixed #(
   parameter int DIV0  = 6,
   parameter int DIV1  = 10,
   parameter int CODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_b,
   output logic [CODES-1:0] fix_tick
);

   localparam int MAXD = (DIV0 > DIV1) ? DIV0 : DIV1;
   localparam int PW   = $clog2(MAXD + 1);
   localparam int RW   = CODES - 1;

   logic [PW-1:0]    pcnt_q;
   logic [PW-1:0]    lim;
   logic             base_hit;
   logic [RW-1:0]    rc_q;
   logic [CODES-1:0] hit_v;
   logic [CODES-1:0] fix_q;

   assign lim      = set_b ? PW'(DIV1 - 1) : PW'(DIV0 - 1);
   assign base_hit = (pcnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         rc_q   <= '0;
      end else begin
         pcnt_q <= base_hit ? '0 : pcnt_q + PW'(1);
         if (base_hit) rc_q <= rc_q + RW'(1);
      end
   end

   for (genvar c = 0; c < CODES; c++) begin : g_rate
      if (c == 0) begin : g_base
         assign hit_v[c] = base_hit;
      end else begin : g_div
         assign hit_v[c] = base_hit && (&rc_q[c-1:0]);
         AST_FIX_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            fix_q[c] |-> fix_q[c-1]) else $error("slow rate without faster one"); // R9
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fix_q <= '0;
      else        fix_q <= hit_v;
   end

   assign fix_tick = fix_q;

endmodule

// File: rtl/btg_pick.sv
module btg_pick
   import btg_pkg::*;
#(
   parameter int CODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       code,
   input  logic             tmr_tick,
   input  logic [CODES-1:0] fix_tick,
   output logic             tick_o
);

   always_comb begin
      tick_o = 1'b0;
      if (code == SRC_TIMER) begin
         tick_o = tmr_tick;
      end else begin
         for (int c = 0; c < CODES; c++) begin
            if (code == 4'(c)) tick_o = fix_tick[c];
         end
      end
   end

   AST_SRC_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> (tmr_tick || (|fix_tick))) else $error("enable with no source"); // R8

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import btg_pkg::*;
#(
   parameter int PRESET_W  = 16,
   parameter int FIX_DIV0  = 6,
   parameter int FIX_DIV1  = 10,
   parameter int FIX_CODES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [3:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              rx_tick,
   output logic              tx_tick
);

   localparam int DIRS = 2;

   if (PRESET_W <= DATA_W || PRESET_W > 2 * DATA_W) begin : g_bad_w
      $error("PRESET_W must span two bus bytes");
   end
   if (FIX_CODES < 2 || FIX_CODES > 13) begin : g_bad_codes
      $error("FIX_CODES must lie in 2..13");
   end
   if (FIX_DIV0 < 1 || FIX_DIV1 < 1) begin : g_bad_div
      $error("fixed divisors must be positive");
   end

   clk_sel_t              clk_sel;
   logic                  mode_on;
   logic                  set_b;
   logic [PRESET_W-1:0]   preset;
   logic                  go;
   logic                  tmr_tick;
   logic [FIX_CODES-1:0]  fix_tick;
   logic [3:0]            dir_code [DIRS];
   logic [DIRS-1:0]       dir_tick;

   btg_regs #(.PRESET_W(PRESET_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .clk_sel   (clk_sel),
      .mode_on   (mode_on),
      .set_b     (set_b),
      .preset    (preset),
      .go        (go)
   );

   btg_timer #(.PRESET_W(PRESET_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .mode_on (mode_on),
      .preset  (preset),
      .tick    (tmr_tick)
   );

   btg_fixed #(.DIV0(FIX_DIV0), .DIV1(FIX_DIV1), .CODES(FIX_CODES)) u_fixed (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_b    (set_b),
      .fix_tick (fix_tick)
   );

   assign dir_code[0] = clk_sel.rx;
   assign dir_code[1] = clk_sel.tx;

   for (genvar d = 0; d < DIRS; d++) begin : g_dir
      btg_pick #(.CODES(FIX_CODES)) u_pick (
         .clk      (clk),
         .rst_n    (rst_n),
         .code     (dir_code[d]),
         .tmr_tick (tmr_tick),
         .fix_tick (fix_tick),
         .tick_o   (dir_tick[d])
      );
   end

   assign rx_tick = dir_tick[0];
   assign tx_tick = dir_tick[1];

   AST_SILENT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) == 1'b0 && clk_sel.rx == SRC_SILENT) |-> !rx_tick)
      else $error("silent code produced enable"); // R10

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       rx_tick;
   logic       tx_tick;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   baud_tick_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .rx_tick   (rx_tick),
      .tx_tick   (tx_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      bus_en = 1'b0;
   endtask

   function automatic logic pick(input bit dir_tx);
      return dir_tx ? tx_tick : rx_tick;
   endfunction

   // counts negedges until a tick on the chosen direction, -1 if none
   task automatic wait_tick(input bit dir_tx, input int limit, output int n);
      n = -1;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (pick(dir_tx)) begin n = k; return; end
      end
   endtask

   task automatic count_ticks(input bit dir_tx, input int cycles, output int n);
      n = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (pick(dir_tx)) n++;
      end
   endtask

   task automatic set_preset(input int p);
      wr(4'h6, 8'(p >> 8));
      wr(4'h7, 8'(p));
   endtask

   task automatic t_reset();
      int nr, nt;
      fork
         count_ticks(1'b0, 60, nr);
         begin
            nt = 0;
            for (int k = 0; k < 60; k++) begin
               @(negedge clk);
               if (tx_tick) nt++;
            end
         end
      join
      chk(nr == 0, "R1 rx quiet after reset", nr, 0);
      chk(nt == 0, "R1 tx quiet after reset", nt, 0);
   endtask

   task automatic t_fixed();
      int n;
      wr(4'h1, 8'hF0);
      for (int c = 0; c < 4; c++) begin
         wr(4'h4, 8'h00);
         wr(4'h1, 8'hF0 | 8'(c));
         wait_tick(1'b1, 200, n);
         wait_tick(1'b1, 200, n);
         chk(n == (6 << c), "R9 fixed period set A", n, 6 << c);
      end
      wr(4'h4, 8'h80);
      wr(4'h1, 8'hF2);
      wait_tick(1'b1, 200, n);
      wait_tick(1'b1, 200, n);
      chk(n == 40, "R9 fixed period set B code 2", n, 40);
      count_ticks(1'b0, 100, n);
      chk(n == 0, "R8 rx stays silent while tx runs", n, 0);
   endtask

   task automatic t_unused();
      int n;
      wr(4'h1, 8'hC7);
      count_ticks(1'b1, 200, n);
      chk(n == 0, "R10 tx code 7 silent", n, 0);
      count_ticks(1'b0, 100, n);
      chk(n == 0, "R10 rx code C silent", n, 0);
   endtask

   task automatic t_start_only_read();
      int n;
      wr(4'h4, 8'h60);
      set_preset(2);
      wr(4'h1, 8'hDF);
      wr(4'hE, 8'h00);
      count_ticks(1'b0, 60, n);
      chk(n == 0, "R3 write to start address does not start", n, 0);
      rd(4'hF);
      rd(4'h1);
      count_ticks(1'b0, 60, n);
      chk(n == 0, "R3 other reads do not start", n, 0);
      rd(4'hE);
      wait_tick(1'b0, 50, n);
      chk(n == 4, "R3 first enable after start read", n, 4);
   endtask

   task automatic t_period();
      int n;
      wr(4'h1, 8'hDF);
      set_preset(261);
      rd(4'hE);
      wait_tick(1'b0, 2000, n);
      chk(n == 522, "R2 first enable at 2*P", n, 522);
      wait_tick(1'b0, 2000, n);
      chk(n == 522, "R4 reload period 2*P", n, 522);
      wr(4'h1, 8'hDD);
      set_preset(3);
      rd(4'hE);
      n = -1;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 6) n = (rx_tick && tx_tick) ? 1 : 0;
      end
      chk(n == 1, "R8 timer drives both directions together", n, 1);
   endtask

   task automatic t_clamp();
      int n;
      wr(4'h1, 8'hDF);
      set_preset(1);
      rd(4'hE);
      wait_tick(1'b0, 50, n);
      chk(n == 4, "R6 preset 1 acts as 2", n, 4);
      set_preset(0);
      rd(4'hE);
      wait_tick(1'b0, 50, n);
      chk(n == 4, "R6 preset 0 acts as 2", n, 4);
      wait_tick(1'b0, 50, n);
      chk(n == 4, "R6 clamped reload period", n, 4);
   endtask

   task automatic t_mode();
      int n;
      wr(4'h1, 8'hDF);
      set_preset(3);
      wr(4'h4, 8'h50);
      rd(4'hE);
      count_ticks(1'b0, 100, n);
      chk(n == 0, "R7 no enables outside timer mode", n, 0);
      wr(4'h4, 8'h60);
      wait_tick(1'b0, 20, n);
      chk(n > 0, "R7 counting resumes in timer mode", n, 1);
      wait_tick(1'b0, 20, n);
      chk(n == 6, "R7 resumed period", n, 6);
   endtask

   task automatic t_preset_at_reload();
      int bad, n;
      wr(4'h4, 8'h60);
      wr(4'h1, 8'hDF);
      set_preset(3);
      rd(4'hE);
      bad = 0;
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         if (rx_tick != (k == 6)) bad++;
      end
      chk(bad == 0, "R4 enable pattern before collision", bad, 0);
      wr(4'h7, 8'h05);
      chk(rx_tick == 1'b1, "R5 enable on the colliding reload", int'(rx_tick), 1);
      bad = 0;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (rx_tick != (k == 6 || k == 16)) bad++;
      end
      chk(bad == 0, "R5 old preset kept one period then new", bad, 0);
   endtask

   task automatic t_restart_collision();
      int bad;
      wr(4'h4, 8'h60);
      wr(4'h1, 8'hDF);
      set_preset(4);
      rd(4'hE);
      bad = 0;
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         if (rx_tick) bad++;
      end
      rd(4'hE);
      chk(rx_tick == 1'b0, "R11 start suppresses terminal enable", int'(rx_tick), 0);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (rx_tick != (k == 8)) bad++;
      end
      chk(bad == 0, "R11 next enable a full period after restart", bad, 0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_unused();
      t_start_only_read();
      t_period();
      t_clamp();
      t_mode();
      t_preset_at_reload();
      t_restart_collision();
      finish_run();
   end

endmodule